// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block gathers 64 interrupt sources and turns them into two request lines for a processor: a normal request and a fast request. Each source has an enable bit, a type bit that routes it to the normal or the fast path, and a 4-bit priority. Software drives the block through a small 32-bit register port. Writes are committed on the rising clock edge, and reads are combinational from the current state.

Enables can be flipped one source at a time by writing a source number to a set port or a clear port, so no read-modify-write is needed. The same enable vector can also be accessed as two 32-bit halves. A threshold register gates the normal path by priority. Two vector words name the winning normal source together with its priority, and the winning fast source. Raw, forced and pending bit vectors can be read as 32-bit halves.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all enable, type, force and priority state is zero, the control word reads 0, the threshold reads 0xFFFFFFFF (released), both vector words read 0xFFFFFFFF, and both request outputs are low.
- R2: A write of N (0..63) to offset 0x08 sets only enable bit N, and a write of N to offset 0x0C clears only enable bit N. A value of 64 or more written to either offset changes nothing.
- R3: The enable vector reads and writes as two words: offset 0x10 holds sources 63..32 and offset 0x14 holds sources 31..0.
- R4: The type vector reads and writes at 0x18 (sources 63..32) and 0x1C (sources 31..0). A type bit of 1 routes the source to the fast path, and 0 routes it to the normal path.
- R5: Priority word x (0..7) sits at offset 0x20 + 4*(7-x). Source 8x+j holds its priority in bits 4j+3:4j of that word, and the word reads back as written.
- R6: A source is pending when (raw input OR force bit) AND its enable bit are all true. Raw inputs read at 0x48/0x4C, force bits read and write at 0x50/0x54, normal pending reads at 0x58/0x5C and fast pending at 0x60/0x64. In each pair the first offset holds sources 63..32.
- R7: A write to offset 0x04 with bit 31 set releases the threshold, and the register then reads 0xFFFFFFFF. Any other write stores min(value, 15) and reads it back.
- R8: The normal request is high exactly when some normal pending source has a priority above the stored threshold, or when the threshold is released and any normal source is pending.
- R9: The fast request is high exactly when some fast pending source exists.
- R10: Offset 0x40 reads {source number in bits 31:16, priority in bits 15:0} for the normal pending source with the highest priority. On a tie the higher source number wins. It reads 0xFFFFFFFF when no normal source is pending.
- R11: Offset 0x44 reads the highest-numbered fast pending source, or 0xFFFFFFFF when none is pending.
- R12: Offset 0x00 is a 32-bit control word that reads back as written and has no effect on requests or vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 7 | Byte offset of the register access |
| busWr | input | 1 | Write strobe, committed on the rising edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| srcIn | input | 64 | Raw level of each interrupt source |
| normIrq | output | 1 | Normal interrupt request |
| fastIrq | output | 1 | Fast interrupt request |

## Verification
A corrupted enable bit shows at the pending words and at the vector words in the same cycle as the access that sets it up, because reads are combinational and the state changes at the edge of the write. A wrong priority, type or threshold shows at the request outputs and at the normal vector as soon as the raw inputs are next driven, with no pipeline delay. The bench therefore checks each sweep step right after the write that caused it. It compares against a model that it builds from the register contents it wrote itself.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC = 64;
  localparam int WORD_W  = 32;
  localparam int PRIO_W  = 4;
  localparam int ADDR_W  = 7;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int PRIO_WORDS = NUM_SRC * PRIO_W / WORD_W;
  localparam int PIDX_W  = $clog2(PRIO_WORDS);

  localparam logic [ADDR_W-1:0] A_CTRL   = 7'h00;
  localparam logic [ADDR_W-1:0] A_MASK   = 7'h04;
  localparam logic [ADDR_W-1:0] A_ENNUM  = 7'h08;
  localparam logic [ADDR_W-1:0] A_DISNUM = 7'h0C;
  localparam logic [ADDR_W-1:0] A_ENHI   = 7'h10;
  localparam logic [ADDR_W-1:0] A_ENLO   = 7'h14;
  localparam logic [ADDR_W-1:0] A_TYHI   = 7'h18;
  localparam logic [ADDR_W-1:0] A_TYLO   = 7'h1C;
  localparam logic [ADDR_W-1:0] A_NVEC   = 7'h40;
  localparam logic [ADDR_W-1:0] A_FVEC   = 7'h44;
  localparam logic [ADDR_W-1:0] A_RAWHI  = 7'h48;
  localparam logic [ADDR_W-1:0] A_RAWLO  = 7'h4C;
  localparam logic [ADDR_W-1:0] A_FRCHI  = 7'h50;
  localparam logic [ADDR_W-1:0] A_FRCLO  = 7'h54;
  localparam logic [ADDR_W-1:0] A_NPHI   = 7'h58;
  localparam logic [ADDR_W-1:0] A_NPLO   = 7'h5C;
  localparam logic [ADDR_W-1:0] A_FPHI   = 7'h60;
  localparam logic [ADDR_W-1:0] A_FPLO   = 7'h64;

  typedef enum logic [4:0] {
    RD_ZERO, RD_CTRL, RD_MASK, RD_ENHI, RD_ENLO, RD_TYHI, RD_TYLO, RD_PRIO,
    RD_NVEC, RD_FVEC, RD_RAWHI, RD_RAWLO, RD_FRCHI, RD_FRCLO,
    RD_NPHI, RD_NPLO, RD_FPHI, RD_FPLO
  } rdSel_e;

  typedef struct packed {
    logic              ctrlWr;
    logic              maskWr;
    logic              enNumWr;
    logic              disNumWr;
    logic              enHiWr;
    logic              enLoWr;
    logic              typeHiWr;
    logic              typeLoWr;
    logic              prioWr;
    logic [PIDX_W-1:0] prioIdx;
    logic              forceHiWr;
    logic              forceLoWr;
    rdSel_e            rdSel;
  } strobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output strobe_t           st
);
  logic isPrio;
  assign isPrio = (busAddr[6:5] == 2'b01) && (busAddr[1:0] == 2'b00);

  always_comb begin
    st = '0;
    st.rdSel = RD_ZERO;
    // word x lives at 0x20 + 4*(7-x): index is the inverted word slot
    st.prioIdx = ~busAddr[2 +: PIDX_W];
    if (isPrio) begin
      st.prioWr = busWr;
      st.rdSel  = RD_PRIO;
    end else begin
      unique case (busAddr)
        A_CTRL:   begin st.ctrlWr    = busWr; st.rdSel = RD_CTRL; end
        A_MASK:   begin st.maskWr    = busWr; st.rdSel = RD_MASK; end
        A_ENNUM:  st.enNumWr  = busWr;
        A_DISNUM: st.disNumWr = busWr;
        A_ENHI:   begin st.enHiWr    = busWr; st.rdSel = RD_ENHI; end
        A_ENLO:   begin st.enLoWr    = busWr; st.rdSel = RD_ENLO; end
        A_TYHI:   begin st.typeHiWr  = busWr; st.rdSel = RD_TYHI; end
        A_TYLO:   begin st.typeLoWr  = busWr; st.rdSel = RD_TYLO; end
        A_NVEC:   st.rdSel = RD_NVEC;
        A_FVEC:   st.rdSel = RD_FVEC;
        A_RAWHI:  st.rdSel = RD_RAWHI;
        A_RAWLO:  st.rdSel = RD_RAWLO;
        A_FRCHI:  begin st.forceHiWr = busWr; st.rdSel = RD_FRCHI; end
        A_FRCLO:  begin st.forceLoWr = busWr; st.rdSel = RD_FRCLO; end
        A_NPHI:   st.rdSel = RD_NPHI;
        A_NPLO:   st.rdSel = RD_NPLO;
        A_FPHI:   st.rdSel = RD_FPHI;
        A_FPLO:   st.rdSel = RD_FPLO;
        default:  st.rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [WORD_W-1:0]  rdData,
  output logic               normIrq,
  output logic               fastIrq,
  output logic [NUM_SRC-1:0] enVec,
  output logic [WORD_W-1:0]  normVecWord,
  output logic [WORD_W-1:0]  fastVecWord,
  output logic [WORD_W-1:0]  maskWord
);
  localparam int HALF = NUM_SRC / 2;
  localparam logic [PRIO_W-1:0] PRIO_MAX = '1;

  logic [WORD_W-1:0]            ctrlReg;
  logic                         maskRel;
  logic [PRIO_W-1:0]            maskLvl;
  logic [NUM_SRC-1:0]           typeVec, forceVec;
  logic [NUM_SRC*PRIO_W-1:0]    prioFlat;
  logic                         numValid;
  logic [NUM_SRC-1:0]           numBit;

  assign numValid = (wrData[WORD_W-1:IDX_W] == '0);
  assign numBit   = {{(NUM_SRC-1){1'b0}}, 1'b1} << wrData[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      maskRel  <= 1'b1;
      maskLvl  <= '0;
      enVec    <= '0;
      typeVec  <= '0;
      forceVec <= '0;
      prioFlat <= '0;
    end else begin
      if (st.ctrlWr) ctrlReg <= wrData;
      if (st.maskWr) begin
        maskRel <= wrData[WORD_W-1];
        maskLvl <= (wrData > WORD_W'(PRIO_MAX)) ? PRIO_MAX : wrData[PRIO_W-1:0];
      end
      if (st.enNumWr && numValid)  enVec <= enVec | numBit;
      if (st.disNumWr && numValid) enVec <= enVec & ~numBit;
      if (st.enHiWr)    enVec[NUM_SRC-1:HALF]    <= wrData;
      if (st.enLoWr)    enVec[HALF-1:0]          <= wrData;
      if (st.typeHiWr)  typeVec[NUM_SRC-1:HALF]  <= wrData;
      if (st.typeLoWr)  typeVec[HALF-1:0]        <= wrData;
      if (st.forceHiWr) forceVec[NUM_SRC-1:HALF] <= wrData;
      if (st.forceLoWr) forceVec[HALF-1:0]       <= wrData;
      if (st.prioWr)    prioFlat[st.prioIdx*WORD_W +: WORD_W] <= wrData;
    end
  end

  logic [NUM_SRC-1:0] anyPend, normPend, fastPend;
  assign anyPend  = (srcIn | forceVec) & enVec;
  assign normPend = anyPend & ~typeVec;
  assign fastPend = anyPend & typeVec;

  // Normal arbitration: ascending scan with >= lets the higher number win ties
  logic              nFound;
  logic [IDX_W-1:0]  nIdx;
  logic [PRIO_W-1:0] nPrio;
  logic              nAbove;
  always_comb begin
    nFound = 1'b0;
    nIdx   = '0;
    nPrio  = '0;
    nAbove = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (normPend[i]) begin
        if (maskRel || prioFlat[i*PRIO_W +: PRIO_W] > maskLvl) nAbove = 1'b1;
        if (!nFound || prioFlat[i*PRIO_W +: PRIO_W] >= nPrio) begin
          nFound = 1'b1;
          nIdx   = IDX_W'(i);
          nPrio  = prioFlat[i*PRIO_W +: PRIO_W];
        end
      end
    end
  end

  logic             fFound;
  logic [IDX_W-1:0] fIdx;
  always_comb begin
    fFound = 1'b0;
    fIdx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (fastPend[i]) begin
        fFound = 1'b1;
        fIdx   = IDX_W'(i);
      end
    end
  end

  assign normIrq     = nAbove;
  assign fastIrq     = |fastPend;
  assign normVecWord = nFound ? {16'(nIdx), 16'(nPrio)} : '1;
  assign fastVecWord = fFound ? WORD_W'(fIdx) : '1;
  assign maskWord    = maskRel ? '1 : WORD_W'(maskLvl);

  always_comb begin
    unique case (st.rdSel)
      RD_CTRL:  rdData = ctrlReg;
      RD_MASK:  rdData = maskWord;
      RD_ENHI:  rdData = enVec[NUM_SRC-1:HALF];
      RD_ENLO:  rdData = enVec[HALF-1:0];
      RD_TYHI:  rdData = typeVec[NUM_SRC-1:HALF];
      RD_TYLO:  rdData = typeVec[HALF-1:0];
      RD_PRIO:  rdData = prioFlat[st.prioIdx*WORD_W +: WORD_W];
      RD_NVEC:  rdData = normVecWord;
      RD_FVEC:  rdData = fastVecWord;
      RD_RAWHI: rdData = srcIn[NUM_SRC-1:HALF];
      RD_RAWLO: rdData = srcIn[HALF-1:0];
      RD_FRCHI: rdData = forceVec[NUM_SRC-1:HALF];
      RD_FRCLO: rdData = forceVec[HALF-1:0];
      RD_NPHI:  rdData = normPend[NUM_SRC-1:HALF];
      RD_NPLO:  rdData = normPend[HALF-1:0];
      RD_FPHI:  rdData = fastPend[NUM_SRC-1:HALF];
      RD_FPLO:  rdData = fastPend[HALF-1:0];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic [WORD_W-1:0]  busWrData,
  output logic [WORD_W-1:0]  busRdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               normIrq,
  output logic               fastIrq
);
  strobe_t            st;
  logic [NUM_SRC-1:0] enVec;
  logic [WORD_W-1:0]  normVecWord, fastVecWord, maskWord;

  irqc_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .st      (st)
  );

  irqc_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .wrData      (busWrData),
    .srcIn       (srcIn),
    .rdData      (busRdData),
    .normIrq     (normIrq),
    .fastIrq     (fastIrq),
    .enVec       (enVec),
    .normVecWord (normVecWord),
    .fastVecWord (fastVecWord),
    .maskWord    (maskWord)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWr,
  input logic [WORD_W-1:0]  busWrData,
  input logic               normIrq,
  input logic               fastIrq,
  input logic [NUM_SRC-1:0] enVec,
  input logic [WORD_W-1:0]  normVecWord,
  input logic [WORD_W-1:0]  fastVecWord,
  input logic [WORD_W-1:0]  maskWord
);
  logic numOk;
  assign numOk = (busWrData[WORD_W-1:IDX_W] == '0);

  // R2
  en_num_sets_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_ENNUM && numOk) |=>
      enVec == ($past(enVec) | (64'd1 << $past(busWrData[IDX_W-1:0]))));

  // R2
  dis_num_clears_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_DISNUM && numOk) |=>
      enVec == ($past(enVec) & ~(64'd1 << $past(busWrData[IDX_W-1:0]))));

  // R2
  num_out_of_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr == A_ENNUM || busAddr == A_DISNUM) && !numOk) |=> $stable(enVec));

  // R7
  mask_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_MASK && !busWrData[WORD_W-1]) |=>
      maskWord == (($past(busWrData) > 32'd15) ? 32'd15 : $past(busWrData)));

  // R7
  mask_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_MASK && busWrData[WORD_W-1]) |=> maskWord == '1);

  // R8
  norm_req_has_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    normIrq |-> normVecWord != '1);

  // R9
  fast_req_matches_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    fastIrq == (fastVecWord != '1));

  // R10
  norm_vector_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (normVecWord != '1) |-> (normVecWord[31:16] < 16'd64 && normVecWord[15:4] == '0));
endmodule

bind irq_vector_ctrl irqc_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWr       (busWr),
  .busWrData   (busWrData),
  .normIrq     (normIrq),
  .fastIrq     (fastIrq),
  .enVec       (enVec),
  .normVecWord (normVecWord),
  .fastVecWord (fastVecWord),
  .maskWord    (maskWord)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [63:0] srcIn = '0;
  logic        normIrq, fastIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [63:0] mEn = '0, mType = '0, mForce = '0;
  logic [3:0]  mPrio [64];
  logic        mRel = 1'b1;
  logic [3:0]  mMask = '0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .srcIn(srcIn),
    .normIrq(normIrq), .fastIrq(fastIrq)
  );

  function automatic logic [63:0] nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    busAddr = a;
    #2;
    d = busRdData;
  endtask

  function automatic logic [31:0] expNorm();
    logic found = 0;
    int idx = 0;
    int pr = 0;
    logic [63:0] p = (srcIn | mForce) & mEn & ~mType;
    for (int i = 0; i < 64; i++)
      if (p[i] && (!found || int'(mPrio[i]) >= pr)) begin
        found = 1; idx = i; pr = int'(mPrio[i]);
      end
    return found ? {16'(idx), 16'(pr)} : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] expFast();
    logic [31:0] r = 32'hFFFF_FFFF;
    logic [63:0] p = (srcIn | mForce) & mEn & mType;
    for (int i = 0; i < 64; i++) if (p[i]) r = 32'(i);
    return r;
  endfunction

  function automatic logic expNormIrq();
    logic r = 0;
    logic [63:0] p = (srcIn | mForce) & mEn & ~mType;
    for (int i = 0; i < 64; i++)
      if (p[i] && (mRel || mPrio[i] > mMask)) r = 1;
    return r;
  endfunction

  task automatic loadPrio();
    for (int x = 0; x < 8; x++) begin
      logic [31:0] w;
      for (int j = 0; j < 8; j++) w[4*j +: 4] = mPrio[8*x + j];
      wr(7'(32 + 4*(7 - x)), w);
    end
  endtask

  task automatic checkStatus(string tag);
    logic [31:0] v;
    logic [63:0] np = (srcIn | mForce) & mEn & ~mType;
    logic [63:0] fp = (srcIn | mForce) & mEn & mType;
    @(negedge clk);
    rd(7'h58, v); chk({"R6 npend hi ", tag}, v, np[63:32]);
    rd(7'h5C, v); chk({"R6 npend lo ", tag}, v, np[31:0]);
    rd(7'h60, v); chk({"R6 fpend hi ", tag}, v, fp[63:32]);
    rd(7'h64, v); chk({"R6 fpend lo ", tag}, v, fp[31:0]);
    rd(7'h48, v); chk({"R6 raw hi ", tag}, v, srcIn[63:32]);
    rd(7'h40, v); chk({"R10 nvec ", tag}, v, expNorm());
    rd(7'h44, v); chk({"R11 fvec ", tag}, v, expFast());
    chk({"R8 normIrq ", tag}, 32'(normIrq), 32'(expNormIrq()));
    chk({"R9 fastIrq ", tag}, 32'(fastIrq), 32'(fp != 0));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 64; i++) mPrio[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(7'h10, v); chk("R1 enable hi", v, 0);
    rd(7'h14, v); chk("R1 enable lo", v, 0);
    rd(7'h18, v); chk("R1 type hi", v, 0);
    rd(7'h50, v); chk("R1 force hi", v, 0);
    rd(7'h3C, v); chk("R1 prio word0", v, 0);
    rd(7'h00, v); chk("R1 ctrl", v, 0);
    rd(7'h04, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(7'h40, v); chk("R1 nvec", v, 32'hFFFF_FFFF);
    rd(7'h44, v); chk("R1 fvec", v, 32'hFFFF_FFFF);
    chk("R1 irqs", {30'd0, normIrq, fastIrq}, 0);

    // R2 set/clear by number, every source
    for (int n = 0; n < 64; n++) begin
      wr(7'h08, 32'(n)); mEn[n] = 1'b1;
      rd(7'h10, v); chk("R2 set hi", v, mEn[63:32]);
      rd(7'h14, v); chk("R2 set lo", v, mEn[31:0]);
    end
    for (int n = 0; n < 64; n += 3) begin
      wr(7'h0C, 32'(n)); mEn[n] = 1'b0;
      rd(7'h10, v); chk("R2 clr hi", v, mEn[63:32]);
      rd(7'h14, v); chk("R2 clr lo", v, mEn[31:0]);
    end
    wr(7'h0C, 32'd64); wr(7'h0C, 32'h8000_0001); wr(7'h08, 32'd66);
    rd(7'h10, v); chk("R2 range hi", v, mEn[63:32]);
    rd(7'h14, v); chk("R2 range lo", v, mEn[31:0]);

    // R3 halves
    wr(7'h10, 32'hDEAD_BEEF); wr(7'h14, 32'h1234_5678);
    mEn = 64'hDEAD_BEEF_1234_5678;
    rd(7'h10, v); chk("R3 enable hi", v, 32'hDEAD_BEEF);
    rd(7'h14, v); chk("R3 enable lo", v, 32'h1234_5678);
    wr(7'h08, 32'd32); mEn[32] = 1'b1;
    rd(7'h10, v); chk("R3 hi holds source 32", v, mEn[63:32]);

    // R4 type halves
    wr(7'h18, 32'h0F0F_00FF); wr(7'h1C, 32'hA000_0005);
    mType = 64'h0F0F_00FF_A000_0005;
    rd(7'h18, v); chk("R4 type hi", v, 32'h0F0F_00FF);
    rd(7'h1C, v); chk("R4 type lo", v, 32'hA000_0005);

    // R5 priority word placement
    for (int i = 0; i < 64; i++) mPrio[i] = 4'((i * 7 + 3) % 16);
    loadPrio();
    for (int x = 0; x < 8; x++) begin
      logic [31:0] w;
      for (int j = 0; j < 8; j++) w[4*j +: 4] = mPrio[8*x + j];
      rd(7'(32 + 4*(7 - x)), v); chk("R5 prio word", v, w);
    end

    // R12 control word is inert
    srcIn = 64'h0000_0100_0000_0010;
    checkStatus("pre-ctrl");
    wr(7'h00, 32'hCAFE_F00D);
    rd(7'h00, v); chk("R12 ctrl readback", v, 32'hCAFE_F00D);
    checkStatus("R12 post-ctrl");

    // R6..R11 random patterns
    for (int k = 0; k < 40; k++) begin
      logic [63:0] r1 = nextRand();
      logic [63:0] r2 = nextRand();
      logic [63:0] r3 = nextRand();
      mEn = r1 | r2; mType = r2 & r3 & {32'h0, r1[31:0] | r1[63:32]};
      mForce = (k % 4 == 0) ? (r3 & ~r1) : (r3 & r1 & r2);
      wr(7'h10, mEn[63:32]); wr(7'h14, mEn[31:0]);
      wr(7'h18, mType[63:32]); wr(7'h1C, mType[31:0]);
      wr(7'h50, mForce[63:32]); wr(7'h54, mForce[31:0]);
      rd(7'h54, v); chk("R6 force lo", v, mForce[31:0]);
      @(negedge clk); srcIn = (k < 5) ? 64'd0 : (nextRand() & nextRand());
      checkStatus("rand");
    end

    // R7/R8 threshold sweep with a single normal source
    mType = '0; mForce = '0; mEn = '0;
    wr(7'h18, 0); wr(7'h1C, 0); wr(7'h50, 0); wr(7'h54, 0);
    wr(7'h10, 0); wr(7'h14, 0);
    wr(7'h08, 32'd41); mEn[41] = 1'b1;
    srcIn = 64'd1 << 41;
    for (int m = 0; m < 20; m++) begin
      wr(7'h04, 32'(m));
      mRel = 1'b0; mMask = (m > 15) ? 4'd15 : 4'(m);
      rd(7'h04, v); chk("R7 mask saturate", v, 32'(mMask));
      chk("R8 threshold", 32'(normIrq), 32'(mPrio[41] > mMask));
    end
    wr(7'h04, 32'hFFFF_FFFF); mRel = 1'b1;
    rd(7'h04, v); chk("R7 release", v, 32'hFFFF_FFFF);
    chk("R8 released", 32'(normIrq), 1);

    // R10 tie: equal priority, higher number wins
    mPrio[5] = 4'd9; mPrio[41] = 4'd9; mPrio[60] = 4'd2;
    loadPrio();
    wr(7'h08, 32'd5); mEn[5] = 1'b1;
    wr(7'h08, 32'd60); mEn[60] = 1'b1;
    srcIn = (64'd1 << 41) | (64'd1 << 5) | (64'd1 << 60);
    rd(7'h40, v); chk("R10 tie", v, {16'd41, 16'd9});
    checkStatus("R10 tie");

    // R11 fast vector among several
    wr(7'h18, 32'h1000_0000); wr(7'h1C, 32'h0000_0020);
    mType = 64'h1000_0000_0000_0020;
    srcIn = 64'h1000_0000_0000_0020;
    mEn = 64'h1000_0000_0000_0020;
    wr(7'h10, mEn[63:32]); wr(7'h14, mEn[31:0]);
    rd(7'h44, v); chk("R11 fvec high", v, 32'd60);
    checkStatus("R11");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule